// File: doc/BRIEF.md
# Page Buffer Load Controller

This block gathers byte writes into a page buffer and decides on its own when a page load is finished. The load has no commit command. A load stays open while byte writes keep arriving, and it closes when no accepted write has been seen for a programmable number of timebase ticks. When it closes, the controller issues a one-cycle start pulse and holds a busy flag for a fixed number of ticks. During that time the downstream array takes the whole buffer in one operation.

Each accepted write does three things. It stores its data at the byte offset given by the low address bits. It records its full address and data as the "last byte loaded". It sets the page address from the high address bits, so the page that gets programmed is the page of the final byte. The first write of a load fills the whole buffer with FFh before it stores its own byte. Offsets that the host never writes therefore program as FFh. A write is accepted only when the command decoder's permission input is high and no programming cycle is running.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset, busy and start are 0, every buffer byte is FFh, and the page address, last address and last data are 0.
- R2: An accepted write while idle sets every buffer byte to FFh except the offset given by address bits 6..0, which takes the written data. Byte k of the buffer appears on page_data_o bits 8k+7..8k.
- R3: A later write to an offset already written in the same load replaces that byte. All other bytes keep their values.
- R4: Each accepted write updates last_addr_o and last_data_o. page_addr_o always equals address bits 17..7 of the last accepted write.
- R5: While loading, an accepted write before the window expires restarts the inactivity count, and loading continues.
- R6: When LOAD_TO_TICKS ticks pass in the load state with no accepted write, start_o is 1 for exactly one cycle. busy_o rises in that same cycle.
- R7: busy_o stays 1 for exactly PROG_TICKS ticks and falls on the clock edge of the last of them. Nothing ends it early.
- R8: Write strobes while busy_o is 1 change neither the buffer nor the last address and data.
- R9: A write strobe with wr_allow_i low is ignored. It starts no load, refreshes no window, and changes no output.
- R10: If an accepted write and a tick arrive in the same cycle, the write wins and the inactivity count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb_i | input | 1 | Byte write strobe, one cycle per byte |
| wr_addr_i | input | 18 | Byte address; bits 6..0 give the offset, bits 17..7 give the page |
| wr_data_i | input | 8 | Byte data |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| wr_allow_i | input | 1 | Write permission from the command decoder |
| page_data_o | output | 1024 | Buffer contents, byte k at bits 8k+7..8k |
| page_addr_o | output | 11 | Page address of the last accepted write |
| start_o | output | 1 | One-cycle pulse that starts the programming cycle |
| busy_o | output | 1 | High during the programming cycle |
| last_addr_o | output | 18 | Address of the last accepted write |
| last_data_o | output | 8 | Data of the last accepted write |

## Verification
The assertions check, on every cycle, the rules around the start pulse: it lasts one cycle, it comes with the rising edge of busy, and it follows a tick. They also check that busy falls only after a tick. Finally they check that the buffer and the last-byte record stay frozen while busy, and stay unchanged after a strobe that was not permitted. The exact length of the load window and of the programming cycle cannot be seen as a local property. Neither can the FFh preset, byte replacement, the page taken from the final write, or write-over-tick priority. The bench's reference model shows these, compared cycle by cycle under directed and random traffic.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } plc_state_e;
endpackage

// File: rtl/plc_tick_timer.sv
// Counts timebase ticks while enabled; flags the tick that reaches LIMIT.
module plc_tick_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expire_o = en_i && !clr_i && tick_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || !en_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/plc_page_buf.sv
// Byte-wide page buffer with a whole-page FFh preset and a single byte write port.
module plc_page_buf #(
  parameter int unsigned BYTES  = 128,
  parameter int unsigned DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      preset_i,
  input  logic                      we_i,
  input  logic [$clog2(BYTES)-1:0]  col_i,
  input  logic [DATA_W-1:0]         data_i,
  output logic [BYTES*DATA_W-1:0]   page_o
);
  localparam int unsigned COL_W = $clog2(BYTES);

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    logic              hit;
    logic [DATA_W-1:0] b_q;

    assign hit = we_i && (col_i == COL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b_q <= '1;
      end else if (hit) begin
        b_q <= data_i;
      end else if (preset_i) begin
        b_q <= '1;
      end
    end

    assign page_o[g*DATA_W +: DATA_W] = b_q;
  end
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
  import plc_pkg::*;
#(
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned PAGE_BYTES    = 128,
  parameter int unsigned LOAD_TO_TICKS = 200,
  parameter int unsigned PROG_TICKS    = 5000
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_stb_i,
  input  logic [ADDR_W-1:0]                  wr_addr_i,
  input  logic [DATA_W-1:0]                  wr_data_i,
  input  logic                               tick_i,
  input  logic                               wr_allow_i,
  output logic [PAGE_BYTES*DATA_W-1:0]       page_data_o,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_addr_o,
  output logic                               start_o,
  output logic                               busy_o,
  output logic [ADDR_W-1:0]                  last_addr_o,
  output logic [DATA_W-1:0]                  last_data_o
);
  localparam int unsigned COL_W = $clog2(PAGE_BYTES);

  plc_state_e        state_q, state_d;
  logic              start_q, start_d;
  logic [ADDR_W-1:0] last_addr_q;
  logic [DATA_W-1:0] last_data_q;
  logic              accept, preset, load_exp, prog_exp;

  assign accept = wr_stb_i && wr_allow_i && (state_q != ST_PROG);
  assign preset = accept && (state_q == ST_IDLE);

  plc_tick_timer #(.LIMIT(LOAD_TO_TICKS)) u_load_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (state_q == ST_LOAD),
    .clr_i   (accept),
    .tick_i  (tick_i),
    .expire_o(load_exp)
  );

  plc_tick_timer #(.LIMIT(PROG_TICKS)) u_prog_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (state_q == ST_PROG),
    .clr_i   (1'b0),
    .tick_i  (tick_i),
    .expire_o(prog_exp)
  );

  plc_page_buf #(.BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .preset_i(preset),
    .we_i    (accept),
    .col_i   (wr_addr_i[COL_W-1:0]),
    .data_i  (wr_data_i),
    .page_o  (page_data_o)
  );

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_LOAD;
      ST_LOAD: if (load_exp) begin
        state_d = ST_PROG;
        start_d = 1'b1;
      end
      ST_PROG: if (prog_exp) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr_q <= '0;
      last_data_q <= '0;
    end else if (accept) begin
      last_addr_q <= wr_addr_i;
      last_data_q <= wr_data_i;
    end
  end

  assign start_o     = start_q;
  assign busy_o      = (state_q == ST_PROG);
  assign last_addr_o = last_addr_q;
  assign last_data_o = last_data_q;
  assign page_addr_o = last_addr_q[ADDR_W-1:COL_W];
endmodule

// File: rtl/plc_checker.sv
module plc_checker #(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PAGE_BYTES = 128
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_allow_i,
  input logic                         tick_i,
  input logic                         start_o,
  input logic                         busy_o,
  input logic [PAGE_BYTES*DATA_W-1:0] page_data_o,
  input logic [ADDR_W-1:0]            last_addr_o,
  input logic [DATA_W-1:0]            last_data_o
);
  p_start_with_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> busy_o);

  p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  p_busy_rise_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> start_o);

  p_start_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(tick_i));

  p_busy_end_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(tick_i));

  p_buf_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(page_data_o));

  p_last_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(last_addr_o) && $stable(last_data_o)));

  p_denied_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_allow_i |=> ($stable(last_addr_o) && $stable(page_data_o)));
endmodule

bind page_load_ctrl plc_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .PAGE_BYTES(PAGE_BYTES)
) u_plc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_allow_i (wr_allow_i),
  .tick_i     (tick_i),
  .start_o    (start_o),
  .busy_o     (busy_o),
  .page_data_o(page_data_o),
  .last_addr_o(last_addr_o),
  .last_data_o(last_data_o)
);

// File: tb/tb_page_load_ctrl.sv
module tb_page_load_ctrl;
  localparam int unsigned LOAD_TO = 4;
  localparam int unsigned PROG    = 6;
  localparam int unsigned NB      = 128;

  logic          clk;
  logic          rst_n;
  logic          wr_stb_i;
  logic [17:0]   wr_addr_i;
  logic [7:0]    wr_data_i;
  logic          tick_i;
  logic          wr_allow_i;
  logic [1023:0] page_data_o;
  logic [10:0]   page_addr_o;
  logic          start_o;
  logic          busy_o;
  logic [17:0]   last_addr_o;
  logic [7:0]    last_data_o;

  page_load_ctrl #(
    .LOAD_TO_TICKS(LOAD_TO),
    .PROG_TICKS   (PROG)
  ) dut (
    .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .tick_i(tick_i), .wr_allow_i(wr_allow_i),
    .page_data_o(page_data_o), .page_addr_o(page_addr_o), .start_o(start_o),
    .busy_o(busy_o), .last_addr_o(last_addr_o), .last_data_o(last_data_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int   n_chk  = 0;
  int   n_err  = 0;
  bit   done   = 0;

  // reference model state: 0 idle, 1 loading, 2 programming
  int          m_st;
  int          m_cnt;
  logic [7:0]  m_buf [NB];
  logic [17:0] m_addr;
  logic [7:0]  m_data;
  logic        m_start;

  function automatic logic [1023:0] m_flat();
    logic [1023:0] v;
    for (int i = 0; i < NB; i++) v[i*8 +: 8] = m_buf[i];
    return v;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [1023:0] act, input logic [1023:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "busy",  1024'(busy_o),      1024'(m_st == 2));
    chk(tag, "start", 1024'(start_o),     1024'(m_start));
    chk(tag, "page",  1024'(page_addr_o), 1024'(m_addr[17:7]));
    chk(tag, "laddr", 1024'(last_addr_o), 1024'(m_addr));
    chk(tag, "ldata", 1024'(last_data_o), 1024'(m_data));
    chk(tag, "buf",   page_data_o,        m_flat());
  endtask

  task automatic model_edge(input logic s, input logic a, input logic [17:0] ad,
                            input logic [7:0] d, input logic t);
    logic acc;
    acc     = s && a && (m_st != 2);
    m_start = 1'b0;
    if (m_st == 0) begin
      if (acc) begin
        for (int i = 0; i < NB; i++) m_buf[i] = 8'hFF;
        m_st = 1; m_cnt = 0;
      end
    end else if (m_st == 1) begin
      if (acc) m_cnt = 0;
      else if (t) begin
        m_cnt++;
        if (m_cnt == LOAD_TO) begin m_st = 2; m_cnt = 0; m_start = 1'b1; end
      end
    end else begin
      if (t) begin
        m_cnt++;
        if (m_cnt == PROG) begin m_st = 0; m_cnt = 0; end
      end
    end
    if (acc) begin
      m_buf[ad[6:0]] = d;
      m_addr = ad;
      m_data = d;
    end
  endtask

  // drive at falling edge, model at rising edge, sample at next falling edge
  task automatic step(input logic s, input logic a, input logic [17:0] ad,
                      input logic [7:0] d, input logic t, input string tag);
    wr_stb_i = s; wr_allow_i = a; wr_addr_i = ad; wr_data_i = d; tick_i = t;
    @(posedge clk);
    model_edge(s, a, ad, d, t);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input logic t, input string tag);
    step(1'b0, 1'b1, 18'h0, 8'h0, t, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; wr_stb_i = 0; wr_allow_i = 1; wr_addr_i = '0;
    wr_data_i = '0; tick_i = 0;
    m_st = 0; m_cnt = 0; m_addr = '0; m_data = '0; m_start = 0;
    for (int i = 0; i < NB; i++) m_buf[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2: first byte presets page, R3: overwrite, R4: page from last byte
    step(1, 1, {11'h003, 7'd5},   8'h3C, 0, "R2");
    step(1, 1, {11'h003, 7'd5},   8'hA5, 0, "R3");
    step(1, 1, {11'h155, 7'd127}, 8'h11, 0, "R4");
    // R5: window restarted by a write just before expiry
    for (int i = 0; i < LOAD_TO - 1; i++) idle(1, "R5");
    step(1, 1, {11'h155, 7'd0}, 8'h22, 0, "R5");
    for (int i = 0; i < LOAD_TO - 1; i++) idle(1, "R5");
    // R10: write and tick together, write wins
    step(1, 1, {11'h155, 7'd64}, 8'h33, 1, "R10");
    for (int i = 0; i < LOAD_TO - 1; i++) idle(1, "R10");
    // R9: disallowed strobe ignored, does not refresh window
    step(1, 0, {11'h7FF, 7'd1}, 8'h99, 0, "R9");
    idle(1, "R6");
    idle(0, "R6");
    // R8: writes while busy ignored; R7: busy length
    for (int i = 0; i < PROG; i++) begin
      step(1, 1, {11'h0AA, 7'(i)}, 8'(8'h50 + i), 0, "R8");
      idle(1, "R7");
    end
    idle(0, "R7");
    step(1, 0, {11'h001, 7'd2}, 8'h77, 0, "R9");
    for (int i = 0; i < LOAD_TO + 1; i++) idle(1, "R9");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic s, a, t;
      logic [17:0] ad;
      s  = ($urandom % 100) < 30;
      a  = ($urandom % 100) < 85;
      t  = ($urandom % 100) < 40;
      ad = {9'h0, 2'($urandom), 7'($urandom)};
      step(s, a, ad, 8'($urandom), t, "R2");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule